// File: doc/BRIEF.md
# Multichannel Conversion Sequencer with Ready Flags

This block runs repeated conversions over a set of enabled channels. Each channel is given its own conversion time, counted in clock cycles. A host starts a run by writing a mode command. The channel index comes from the address of that write. The sequencer then walks the enabled channels in rising order and wraps around. Each channel waits out its conversion time. When it completes, the block captures the word on a stub converter input into that channel's data register and raises that channel's ready bit.

The host reaches everything through a small register port: one write strobe and one read strobe, with a read-done strobe that closes a data read. An active-low ready output summarises the ready bits in one of two ways. It can go low when any channel has unread data, or only when every enabled channel has unread data.

Two collisions are handled:
- **Overwrite.** A result that lands on unread data replaces that data. It marks the loss in the channel's status and forces the ready output high for a fixed minimum number of cycles.
- **Read collision.** A result that completes while that channel's data register is being read is thrown away.

Top module: `chan_scan_seq`

## Requirements
- R1: Register map, with address bits [4:3] selecting the region and [2:0] the channel.
  - Region 0 (address c) holds the conversion time of channel c. It is read/write and resets to 1.
  - Region 1 (address 8+c): a write is a mode command, where bit 0 = 1 means continuous run and 0 means idle. A read returns channel c's status.
  - Address 16 is the configuration: bits [7:0] are the channel enables and bit 8 selects the all-channels ready mode. It resets to 0, and addresses 17 to 23 read 0.
  - Region 3 (address 24+c) is channel c's data register, which resets to 0 and ignores writes.
  - Read data appears on `rd_data` in the cycle after the `rd_req` edge.
- R2: Any mode write clears every ready bit and any pending overwrite pulse. From the next cycle `rdy_n` is high and every status ready bit reads 0.
- R3: A continuous command converts first on the addressed channel if it is enabled. Otherwise it starts on the next enabled channel above it, wrapping past 7 to 0. After each completion it moves to the next enabled channel in the same wrapping order.
- R4: Each conversion lasts the channel's programmed time in cycles, with 0 treated as 1. The first ready flag is visible exactly T cycles after the mode-write edge. A full pass lasts the sum of the enabled channels' times.
- R5: A completion stores the value on `sample_data` at the completion edge and sets that channel's ready bit. The status word is: bits [2:0] channel index, bit 3 overwrite flag, bit 4 ready bit, other bits 0.
- R6: Reading a channel's data register clears its ready bit and its overwrite flag.
- R7: With bit 8 at 0, `rdy_n` is low whenever any ready bit is set, except during a forced-high pulse.
- R8: With bit 8 at 1, `rdy_n` is low only when the enable mask is non-zero and every enabled channel's ready bit is set.
- R9: Overwrite of unread data (ready bit set or re-flag pending) has these effects:
  - The data is replaced and the overwrite flag is set.
  - The channel's ready bit reads 0 and `rdy_n` is forced high for exactly 163 cycles.
  - After that the ready bit is set again.
- R10: A completion on channel c is dropped, with its data kept and its ready bit not set, when it falls on the `rd_req` edge of a data read of c or on any later edge up to and including the `rd_done` edge.
- R11: With no channel enabled, a continuous command starts nothing: `rdy_n` stays high and no ready bit rises.
- R12: An idle mode command stops the scan, and no further completions occur.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 5 | Write address |
| wr_data | input | 24 | Write data |
| rd_req | input | 1 | Read strobe; opens a data read window |
| rd_addr | input | 5 | Read address |
| rd_done | input | 1 | Closes an open data read window |
| rd_data | output | 24 | Registered read data |
| sample_data | input | 24 | Stub converter result, captured on completion |
| rdy_n | output | 1 | Active-low data-ready summary |

## Verification
The hardest situation to reach is a completion that lands exactly on the first or the last edge of a data read window, and just outside it. The bench drives a free-running cycle counter as converter data and places the read strobe at computed absolute edges relative to the mode write. It sweeps the strobe across three offsets around the completion edge. The 163-cycle forced-high pulse is reached by giving a single channel a conversion time longer than the pulse and leaving the first result unread. This isolates the overwrite from any other completion, so both pulse edges can be checked to the cycle.

// File: rtl/chan_scan_pkg.sv
package chan_scan_pkg;
  typedef enum logic [1:0] {
    REG_TIME = 2'd0,
    REG_MODE = 2'd1,
    REG_CFG  = 2'd2,
    REG_DATA = 2'd3
  } reg_region_e;

  localparam logic MODE_RUN_BIT = 1'b1;
endpackage

// File: rtl/seq_sched.sv
module seq_sched #(
  parameter int NUM_CH = 8,
  parameter int TIME_W = 16,
  localparam int CH_W = $clog2(NUM_CH)
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          cmd_valid,
  input  logic                          cmd_run,
  input  logic [CH_W-1:0]               cmd_ch,
  input  logic [NUM_CH-1:0]             en_mask,
  input  logic [NUM_CH-1:0][TIME_W-1:0] conv_time,
  output logic                          running,
  output logic                          done,
  output logic [CH_W-1:0]               done_ch
);
  // Wrapping search for an enabled channel; incl selects whether 'from' itself is a candidate first.
  function automatic logic [CH_W:0] pick_next(input logic [NUM_CH-1:0] m,
                                              input logic [CH_W-1:0] from,
                                              input logic incl);
    logic [CH_W:0] r;
    logic hit;
    r = '0;
    hit = 1'b0;
    for (int i = 0; i < NUM_CH; i++) begin
      int off;
      logic [CH_W-1:0] c;
      off = incl ? i : i + 1;
      c = CH_W'((int'(from) + off) % NUM_CH);
      if (!hit && m[c]) begin
        hit = 1'b1;
        r = {1'b1, c};
      end
    end
    return r;
  endfunction

  function automatic logic [TIME_W-1:0] eff_time(input logic [TIME_W-1:0] t);
    return (t == '0) ? TIME_W'(1) : t;
  endfunction

  logic              run_q;
  logic [CH_W-1:0]   cur_q;
  logic [TIME_W-1:0] cnt_q;
  logic [CH_W:0]     first_pick;
  logic [CH_W:0]     next_pick;

  assign first_pick = pick_next(en_mask, cmd_ch, 1'b1);
  assign next_pick  = pick_next(en_mask, cur_q, 1'b0);
  assign done       = run_q && (cnt_q == TIME_W'(1)) && !cmd_valid;
  assign done_ch    = cur_q;
  assign running    = run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      cur_q <= '0;
      cnt_q <= '0;
    end else if (cmd_valid) begin
      if (cmd_run && first_pick[CH_W]) begin
        run_q <= 1'b1;
        cur_q <= first_pick[CH_W-1:0];
        cnt_q <= eff_time(conv_time[first_pick[CH_W-1:0]]);
      end else begin
        run_q <= 1'b0;
      end
    end else if (run_q) begin
      if (cnt_q == TIME_W'(1)) begin
        if (next_pick[CH_W]) begin
          cur_q <= next_pick[CH_W-1:0];
          cnt_q <= eff_time(conv_time[next_pick[CH_W-1:0]]);
        end else begin
          run_q <= 1'b0;
        end
      end else begin
        cnt_q <= cnt_q - TIME_W'(1);
      end
    end
  end

  assert_start_on_enabled_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_run && (en_mask != '0)
    |=> run_q && (((($past(en_mask)) >> cur_q) & NUM_CH'(1)) != '0));

  assert_empty_mask_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && (en_mask == '0) |=> !run_q);

  assert_done_advances_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done && ($countones(en_mask) > 1) |=> run_q && (cur_q != $past(cur_q)));

  assert_idle_cmd_stops_R12: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_run |=> !done);
endmodule

// File: rtl/seq_store.sv
module seq_store #(
  parameter int NUM_CH      = 8,
  parameter int DATA_W      = 24,
  parameter int HOLD_CYCLES = 163,
  localparam int CH_W   = $clog2(NUM_CH),
  localparam int HOLD_W = $clog2(HOLD_CYCLES + 1)
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          clr,
  input  logic                          done,
  input  logic [CH_W-1:0]               done_ch,
  input  logic [DATA_W-1:0]             sample,
  input  logic                          rd_take,
  input  logic [CH_W-1:0]               rd_ch,
  input  logic                          rd_done,
  input  logic                          all_mode,
  input  logic [NUM_CH-1:0]             en_mask,
  output logic [NUM_CH-1:0][DATA_W-1:0] data_q,
  output logic [NUM_CH-1:0]             ready_q,
  output logic [NUM_CH-1:0]             ovr_q,
  output logic                          rdy_n
);
  function automatic logic level_on(input logic [NUM_CH-1:0] rdy,
                                    input logic [NUM_CH-1:0] m,
                                    input logic all);
    return all ? ((m != '0) && ((rdy & m) == m)) : (rdy != '0);
  endfunction

  logic              win_q;
  logic [CH_W-1:0]   win_ch_q;
  logic [NUM_CH-1:0] pend_q;
  logic [HOLD_W-1:0] hold_q;
  logic [NUM_CH-1:0] rdy_d, pend_d, ovr_d;
  logic [HOLD_W-1:0] hold_d;

  // Named internal events for the assertions.
  logic busy_hit, drop_evt, over_evt, fresh_evt;
  assign busy_hit  = (rd_take && (rd_ch == done_ch)) || (win_q && (win_ch_q == done_ch));
  assign drop_evt  = done && busy_hit;
  assign over_evt  = done && !busy_hit && (ready_q[done_ch] || pend_q[done_ch]);
  assign fresh_evt = done && !busy_hit && !ready_q[done_ch] && !pend_q[done_ch];

  always_comb begin
    rdy_d  = ready_q;
    pend_d = pend_q;
    ovr_d  = ovr_q;
    hold_d = hold_q;
    if (hold_q != '0) hold_d = hold_q - HOLD_W'(1);
    if (hold_q == HOLD_W'(1)) begin
      rdy_d  = rdy_d | pend_q;
      pend_d = '0;
    end
    if (fresh_evt) rdy_d[done_ch] = 1'b1;
    if (over_evt) begin
      rdy_d[done_ch]  = 1'b0;
      pend_d[done_ch] = 1'b1;
      ovr_d[done_ch]  = 1'b1;
      hold_d          = HOLD_W'(HOLD_CYCLES);
    end
    if (rd_take) begin
      rdy_d[rd_ch]  = 1'b0;
      pend_d[rd_ch] = 1'b0;
      ovr_d[rd_ch]  = 1'b0;
    end
    if (clr) begin
      rdy_d  = '0;
      pend_d = '0;
      hold_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ready_q  <= '0;
      pend_q   <= '0;
      ovr_q    <= '0;
      hold_q   <= '0;
      win_q    <= 1'b0;
      win_ch_q <= '0;
    end else begin
      ready_q <= rdy_d;
      pend_q  <= pend_d;
      ovr_q   <= ovr_d;
      hold_q  <= hold_d;
      if (rd_take) begin
        win_q    <= 1'b1;
        win_ch_q <= rd_ch;
      end else if (rd_done) begin
        win_q <= 1'b0;
      end
    end
  end

  generate
    for (genvar g = 0; g < NUM_CH; g++) begin : g_data
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
          data_q[g] <= '0;
        else if ((fresh_evt || over_evt) && (done_ch == CH_W'(g)))
          data_q[g] <= sample;
      end
    end
  endgenerate

  assign rdy_n = !((hold_q == '0) && level_on(ready_q, en_mask, all_mode));

  assert_mode_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (ready_q == '0) && rdy_n);

  assert_overwrite_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    over_evt && !clr |=> rdy_n && ovr_q[$past(done_ch)] && !ready_q[$past(done_ch)]);

  assert_drop_keeps_data_R10: assert property (@(posedge clk) disable iff (!rst_n)
    drop_evt |=> $stable(data_q));

  assert_read_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_take |=> !ready_q[$past(rd_ch)] && !ovr_q[$past(rd_ch)]);
endmodule

// File: rtl/chan_scan_seq.sv
module chan_scan_seq
  import chan_scan_pkg::*;
#(
  parameter int NUM_CH      = 8,
  parameter int DATA_W      = 24,
  parameter int TIME_W      = 16,
  parameter int HOLD_CYCLES = 163,
  localparam int CH_W   = $clog2(NUM_CH),
  localparam int ADDR_W = CH_W + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_req,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic              rd_done,
  output logic [DATA_W-1:0] rd_data,
  input  logic [DATA_W-1:0] sample_data,
  output logic              rdy_n
);
  reg_region_e wr_region, rd_region;
  logic [CH_W-1:0] wr_idx, rd_idx;
  assign wr_region = reg_region_e'(wr_addr[ADDR_W-1 -: 2]);
  assign rd_region = reg_region_e'(rd_addr[ADDR_W-1 -: 2]);
  assign wr_idx    = wr_addr[CH_W-1:0];
  assign rd_idx    = rd_addr[CH_W-1:0];

  logic [NUM_CH-1:0][TIME_W-1:0] time_q;
  logic [NUM_CH-1:0]             en_q;
  logic                          all_q;
  wire                           unused_wr = ^wr_data;

  logic mode_wr, rd_take;
  assign mode_wr = wr_en && (wr_region == REG_MODE);
  assign rd_take = rd_req && (rd_region == REG_DATA);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int c = 0; c < NUM_CH; c++) time_q[c] <= TIME_W'(1);
      en_q  <= '0;
      all_q <= 1'b0;
    end else if (wr_en) begin
      if (wr_region == REG_TIME)
        time_q[wr_idx] <= wr_data[TIME_W-1:0];
      if ((wr_region == REG_CFG) && (wr_idx == '0)) begin
        en_q  <= wr_data[NUM_CH-1:0];
        all_q <= wr_data[NUM_CH];
      end
    end
  end

  logic            running, done;
  logic [CH_W-1:0] done_ch;

  seq_sched #(.NUM_CH(NUM_CH), .TIME_W(TIME_W)) sched_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (mode_wr),
    .cmd_run   (wr_data[0] == MODE_RUN_BIT),
    .cmd_ch    (wr_idx),
    .en_mask   (en_q),
    .conv_time (time_q),
    .running   (running),
    .done      (done),
    .done_ch   (done_ch)
  );

  logic [NUM_CH-1:0][DATA_W-1:0] data_q;
  logic [NUM_CH-1:0]             ready_q, ovr_q;

  seq_store #(.NUM_CH(NUM_CH), .DATA_W(DATA_W), .HOLD_CYCLES(HOLD_CYCLES)) store_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (mode_wr),
    .done     (done),
    .done_ch  (done_ch),
    .sample   (sample_data),
    .rd_take  (rd_take),
    .rd_ch    (rd_idx),
    .rd_done  (rd_done),
    .all_mode (all_q),
    .en_mask  (en_q),
    .data_q   (data_q),
    .ready_q  (ready_q),
    .ovr_q    (ovr_q),
    .rdy_n    (rdy_n)
  );

  logic [DATA_W-1:0] rd_mux, rd_q;
  always_comb begin
    rd_mux = '0;
    unique case (rd_region)
      REG_TIME: rd_mux = DATA_W'(time_q[rd_idx]);
      REG_MODE: begin
        rd_mux[CH_W-1:0] = rd_idx;
        rd_mux[CH_W]     = ovr_q[rd_idx];
        rd_mux[CH_W+1]   = ready_q[rd_idx];
      end
      REG_CFG:  if (rd_idx == '0) rd_mux = DATA_W'({all_q, en_q});
      REG_DATA: rd_mux = data_q[rd_idx];
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rd_q <= '0;
    else if (rd_req) rd_q <= rd_mux;
  end
  assign rd_data = rd_q;

  assert_stopped_no_ready_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !running && !$past(running) && (ready_q == '0) && !rd_take |=> (ready_q == '0));
endmodule

// File: tb/chan_scan_seq_tb_top.sv
module chan_scan_seq_tb_top;
  localparam int NCH = 8, DW = 24, AW = 5, HOLD = 163;

  logic clk = 1'b0, rst_n = 1'b0;
  always #10 clk = ~clk;

  logic          wr_en = 0, rd_req = 0, rd_done = 0;
  logic [AW-1:0] wr_addr = '0, rd_addr = '0;
  logic [DW-1:0] wr_data = '0, sample_data, rd_data;
  logic          rdy_n;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [DW-1:0] smp(input int n);
    return DW'(n * 13 + 5);
  endfunction
  assign sample_data = smp(cyc);

  chan_scan_seq dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_req(rd_req), .rd_addr(rd_addr), .rd_done(rd_done), .rd_data(rd_data),
    .sample_data(sample_data), .rdy_n(rdy_n));

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] a_time(input int c); return AW'(c); endfunction
  function automatic logic [AW-1:0] a_mode(input int c); return AW'(8 + c); endfunction
  function automatic logic [AW-1:0] a_data(input int c); return AW'(24 + c); endfunction
  localparam logic [AW-1:0] A_CFG = 5'd16;

  function automatic logic [31:0] stat(input int c, input bit r, input bit o);
    return 32'({r, o, 3'(c)});
  endfunction

  // All tasks are entered and left at a falling edge.
  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d, output int e);
    wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk); e = cyc; wr_en = 0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [DW-1:0] d);
    rd_req = 1; rd_addr = a;
    @(negedge clk); rd_req = 0; rd_done = 1; d = rd_data;
    @(negedge clk); rd_done = 0;
  endtask

  task automatic wait_to(input int t);
    while (cyc < t) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(negedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int e, dmy;
    logic [DW-1:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // Reset state and map (R1, R2)
    chk("R2 reset rdy_n", rdy_n, 1);
    for (int c = 0; c < NCH; c++) begin
      rd(a_time(c), v); chk("R1 time reset", v, 1);
      rd(a_mode(c), v); chk("R5 status reset", v, stat(c, 0, 0));
    end
    rd(A_CFG, v); chk("R1 cfg reset", v, 0);
    rd(AW'(17), v); chk("R1 unmapped", v, 0);
    wr(a_data(2), 24'h123456, dmy);
    rd(a_data(2), v); chk("R1 data write ignored", v, 0);

    // R11: nothing enabled
    wr(a_mode(0), 1, e);
    repeat (40) @(negedge clk);
    chk("R11 rdy_n idle", rdy_n, 1);
    for (int c = 0; c < NCH; c++) begin
      rd(a_mode(c), v); chk("R11 no ready", v, stat(c, 0, 0));
    end

    // R4/R3/R5 sweep: single enabled channel, start from a disabled one
    for (int c = 0; c < NCH; c++) begin
      for (int k = 0; k < 4; k++) begin
        int t, te, s;
        logic [DW-1:0] exp;
        t = (k == 0) ? 0 : (k == 1) ? 1 : (k == 2) ? 2 : 5;
        te = (t == 0) ? 1 : t;
        s = (c + 3) % NCH;
        wr(A_CFG, DW'(1 << c), dmy);
        wr(a_time(c), DW'(t), dmy);
        wr(a_mode(s), 1, e);
        wait_to(e + te - 1);
        chk("R4 not yet ready", rdy_n, 1);
        exp = smp(e + te - 1);
        wait_to(e + te);
        chk("R4 ready at T", rdy_n, 0);
        wr(a_mode(s), 0, dmy);
        chk("R2 idle write raises rdy_n", rdy_n, 1);
        rd(a_data(c), v); chk("R5 data captured", v, exp);
        rd(a_mode(c), v); chk("R2 status cleared", v, stat(c, 0, 0));
      end
    end

    // R3 order and R4 pass length
    begin
      int tm[NCH];
      logic [NCH-1:0] msk;
      msk = 8'b1010_0110;
      tm = '{default: 1};
      tm[1] = 20; tm[2] = 26; tm[5] = 22; tm[7] = 30;
      wr(A_CFG, DW'(msk), dmy);
      for (int c = 0; c < NCH; c++) wr(a_time(c), DW'(tm[c]), dmy);
      for (int si = 0; si < 3; si++) begin
        int s, n, acc;
        int ord[4];
        int cum[4];
        s = (si == 0) ? 5 : (si == 1) ? 3 : 0;
        n = 0; acc = 0;
        for (int i = 0; i < NCH; i++) begin
          int c;
          c = (s + i) % NCH;
          if (msk[c] && n < 4) begin ord[n] = c; acc += tm[c]; cum[n] = acc; n++; end
        end
        wr(a_mode(s), 1, e);
        for (int k = 0; k < 3; k++) begin
          wait_to(e + cum[k]);
          for (int c = 0; c < NCH; c++) begin
            bit r;
            r = 0;
            for (int j = 0; j <= k; j++) if (ord[j] == c) r = 1;
            rd(a_mode(c), v); chk("R3 order status", v, stat(c, r, 0));
          end
        end
        wait_to(e + cum[3]);
        chk("R7 any ready after pass", rdy_n, 0);
        for (int j = 0; j < 4; j++) begin
          rd(a_data(ord[j]), v); chk("R5 pass data", v, smp(e + cum[j] - 1));
        end
        wait_to(e + cum[3] + tm[ord[0]] - 1);
        chk("R4 pass length high", rdy_n, 1);
        wait_to(e + cum[3] + tm[ord[0]]);
        chk("R4 pass length low", rdy_n, 0);
        wr(a_mode(0), 0, dmy);
      end
    end

    // R8 all-channel mode, R6 read clears, R2/R12 stop
    wr(a_time(0), 20, dmy);
    wr(a_time(1), 30, dmy);
    wr(A_CFG, DW'(9'h103), dmy);
    wr(a_mode(0), 1, e);
    wait_to(e + 20);
    chk("R8 one of two ready keeps high", rdy_n, 1);
    rd(a_mode(0), v); chk("R5 ch0 ready bit", v, stat(0, 1, 0));
    wait_to(e + 49);
    chk("R8 still high", rdy_n, 1);
    wait_to(e + 50);
    chk("R8 all ready low", rdy_n, 0);
    rd(a_data(0), v); chk("R5 ch0 data", v, smp(e + 19));
    chk("R6 read raises rdy_n in all mode", rdy_n, 1);
    wait_to(e + 70);
    chk("R8 all ready again", rdy_n, 0);
    wr(a_mode(0), 0, dmy);
    chk("R2 mode write high", rdy_n, 1);
    repeat (100) @(negedge clk);
    chk("R12 stopped", rdy_n, 1);
    rd(a_mode(0), v); chk("R12 ch0 stays clear", v, stat(0, 0, 0));
    rd(a_mode(1), v); chk("R12 ch1 stays clear", v, stat(1, 0, 0));

    // R7 any mode
    wr(A_CFG, DW'(9'h003), dmy);
    wr(a_mode(0), 1, e);
    wait_to(e + 19);
    chk("R7 before first", rdy_n, 1);
    wait_to(e + 20);
    chk("R7 any ready low", rdy_n, 0);
    rd(a_data(0), v); chk("R5 any data", v, smp(e + 19));
    chk("R6 read clears to high", rdy_n, 1);
    rd(a_mode(0), v); chk("R6 status cleared", v, stat(0, 0, 0));
    wait_to(e + 50);
    chk("R7 ch1 ready low", rdy_n, 0);
    wr(a_mode(0), 0, dmy);

    // R9 overwrite pulse
    wr(A_CFG, DW'(1 << 6), dmy);
    wr(a_time(6), 300, dmy);
    wr(a_mode(6), 1, e);
    wait_to(e + 599);
    chk("R9 unread before overwrite", rdy_n, 0);
    wait_to(e + 600);
    chk("R9 forced high", rdy_n, 1);
    rd(a_mode(6), v); chk("R9 status during pulse", v, stat(6, 0, 1));
    wait_to(e + 600 + HOLD - 1);
    chk("R9 pulse last cycle", rdy_n, 1);
    wait_to(e + 600 + HOLD);
    chk("R9 pulse end", rdy_n, 0);
    rd(a_mode(6), v); chk("R9 ready back", v, stat(6, 1, 1));
    rd(a_data(6), v); chk("R9 data replaced", v, smp(e + 599));
    rd(a_mode(6), v); chk("R6 overwrite flag cleared", v, stat(6, 0, 0));
    wr(a_mode(0), 0, dmy);

    // R10 read collision sweep
    wr(A_CFG, DW'(1 << 4), dmy);
    wr(a_time(4), 10, dmy);
    for (int off = 0; off < 3; off++) begin
      bit drop;
      logic [DW-1:0] v1;
      drop = (off <= 1);
      wr(a_mode(4), 1, e);
      wait_to(e + 10);
      chk("R10 first ready", rdy_n, 0);
      v1 = smp(e + 9);
      wait_to(e + 19 - off);
      rd(a_data(4), v); chk("R10 read value", v, v1);
      wait_to(e + 21);
      chk("R10 ready after window", rdy_n, drop ? 1'b1 : 1'b0);
      rd(a_data(4), v); chk("R10 data after window", v, drop ? v1 : smp(e + 19));
      wr(a_mode(0), 0, dmy);
    end

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule